// File: doc/BRIEF.md
# Uncorrectable Error First-Pointer and Header Log Queue

This block holds the record of the first uncorrectable error that a function has seen: a pointer to that error's bit in the uncorrectable status register, a 128-bit header log and a 128-bit prefix log. When software has turned on multiple header recording, errors that arrive while the first one is still pending are kept in a bounded queue and do not disturb the visible log. The status register itself lives outside the block. Its current value and a write strobe come in, and the block returns the status bits that must be set again.

Software clears the pending error by writing one to its status bit. If entries are waiting, the oldest one moves into the log and the pointer follows it. If the queue is empty, or recording is off, the log is wiped. Any write to the capability and control register discards all waiting entries. Error classification and the configuration register interface are outside this block.

Top module: `uerr_first_log`

## Requirements
- R1: After a synchronous active-low reset, `fep` is 0, both logs are zero, `pfx_present`, `overflow` and `reassert_vld` are 0, and the queue is empty.
- R2: A log request that is not queued loads the log. `fep` becomes the bit index of the single set bit of `log_status` (bit 0 gives 0, bit 31 gives 31), visible in the cycle after the request.
- R3: The header log holds input dword k (bits 32k+31..32k) with its four bytes reversed, in the same position, when `log_hdr_vld` is 1. Otherwise it holds zero.
- R4: The prefix log holds the prefix dwords, byte-reversed in the same way, and `pfx_present` is 1, only when both `log_pfx_vld` and `pfx_sup` are 1. Otherwise the prefix log is zero and `pfx_present` is 0.
- R5: When `rec_en` is 1 and `stat_val[fep]` is 1, a log request is queued and leaves `fep` and both logs unchanged. When `rec_en` is 0, the request overwrites the log.
- R6: A request that should be queued while the queue holds DEPTH entries is dropped, and `overflow` pulses high for exactly one cycle.
- R7: A status write with `stat_val[fep]` equal to 0, while recording is off or the queue is empty, clears `fep`, `pfx_present` and both logs. A log request in the same cycle is loaded instead.
- R8: A status write that clears the pointed bit while recording is on and the queue is not empty moves the oldest queued entry into the log, in arrival order.
- R9: Any status write while recording is on and the queue is not empty pulses `reassert_vld` in the next cycle. `reassert_mask` then carries the OR of the status of every queued entry, including one that is popped in that cycle.
- R10: A write to the capability and control register (`cap_wr`) empties the queue. A request that is queued in the same cycle lands in the emptied queue.
- R11: A pop and a push in the same cycle leave the queue occupancy unchanged. A full queue therefore accepts the new entry without overflow, and stays full.
- R12: `mhr_cap` is 1 exactly when the effective depth is non-zero. The depth is clamped to MAX_DEPTH, and a depth of zero disables queueing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_en | input | 1 | Multiple header recording enabled by software |
| pfx_sup | input | 1 | End-to-end prefix support advertised |
| cap_wr | input | 1 | Write strobe of the capability and control register |
| log_req | input | 1 | Error log request |
| log_status | input | 32 | One-hot uncorrectable status of the error |
| log_hdr_vld | input | 1 | Header dwords are valid |
| log_pfx_vld | input | 1 | Prefix dwords are present |
| log_hdr | input | 128 | Four header dwords, dword k at bits 32k+31..32k |
| log_pfx | input | 128 | Four prefix dwords, same layout |
| stat_wr | input | 1 | Software wrote the uncorrectable status register |
| stat_val | input | 32 | Uncorrectable status register value after that write |
| fep | output | 5 | First error pointer |
| pfx_present | output | 1 | Prefix log holds valid data |
| hdr_log | output | 128 | Header log, byte-reversed dwords |
| pfx_log | output | 128 | Prefix log, byte-reversed dwords |
| overflow | output | 1 | One-cycle pulse: a queued error was dropped |
| reassert_vld | output | 1 | One-cycle pulse: set the bits in `reassert_mask` again |
| reassert_mask | output | 32 | Status bits of all queued entries |
| mhr_cap | output | 1 | Multiple header recording is advertised |

## Verification
Every result of this block is registered once. The pointer, both logs, the prefix bit, the overflow pulse and the re-assert pulse with its mask all change at the first rising edge after the stimulus cycle. The bench drives each stimulus just after a falling edge and holds it for one full clock. It samples at the next falling edge, which is exactly one register stage later. It then drops the strobes before the following rising edge and samples again to confirm that the pulse outputs last only one cycle. The queue's occupancy has no port of its own, so it is inferred from when overflow appears and from the order in which entries come back.

// File: rtl/uel_pkg.sv
// Package: shared entry type and pure helper functions for the
// uncorrectable error log. Assumes 32-bit status and four 32-bit dwords
// for both header and prefix.
package uel_pkg;

    localparam int STAT_W  = 32;
    localparam int PTR_W   = 5;
    localparam int NDW     = 4;
    localparam int LOG_W   = NDW * 32;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              hdr_vld;
        logic              pfx_vld;
        logic [LOG_W-1:0]  hdr;
        logic [LOG_W-1:0]  pfx;
    } uel_entry_t;

    // Index of the lowest set bit (0 when none is set)
    function automatic logic [PTR_W-1:0] low_index(input logic [STAT_W-1:0] v);
        logic [PTR_W-1:0] idx;
        idx = '0;
        for (int i = STAT_W - 1; i >= 0; i--) begin
            if (v[i]) idx = PTR_W'(i);
        end
        return idx;
    endfunction

    // Reverse the byte order inside every dword, keeping dword positions
    function automatic logic [LOG_W-1:0] swap_dwords(input logic [LOG_W-1:0] v);
        logic [LOG_W-1:0] o;
        for (int k = 0; k < NDW; k++) begin
            for (int b = 0; b < 4; b++) begin
                o[32*k + 8*b +: 8] = v[32*k + 8*(3-b) +: 8];
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/uel_queue.sv
// Module: uel_queue
// Bounded FIFO of pending error entries, kept as a shift array so the
// oldest entry always sits in slot 0. Supports flush, push, pop and
// pop+push in one cycle. Assumes the caller never pops an empty queue and
// never pushes a full one without a pop or flush in the same cycle.
// DEPTH of zero builds no storage and reports the queue as full and empty.
module uel_queue
    import uel_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = (DEPTH > 0) ? $clog2(DEPTH + 1) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  uel_entry_t    din,
    output uel_entry_t    head,
    output logic          empty,
    output logic          full,
    output logic [STAT_W-1:0] stat_or,
    output logic [CW-1:0] cnt
);

    generate
        if (DEPTH == 0) begin : g_none
            assign head    = '0;
            assign empty   = 1'b1;
            assign full    = 1'b1;
            assign stat_or = '0;
            assign cnt     = '0;
        end else begin : g_fifo
            uel_entry_t      slots [DEPTH+1];
            uel_entry_t      nxt   [DEPTH];
            logic [CW-1:0]   cnt_q;

            // Next value of every slot for flush, pop, push and pop+push
            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    nxt[i] = slots[i];
                    if (flush) begin
                        if (push && i == 0) nxt[i] = din;
                    end else if (pop) begin
                        nxt[i] = slots[i+1];
                        if (push && cnt_q == CW'(i + 1)) nxt[i] = din;
                    end else if (push && cnt_q == CW'(i)) begin
                        nxt[i] = din;
                    end
                end
            end

            // Slot storage update
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i <= DEPTH; i++) slots[i] <= '0;
                end else begin
                    for (int i = 0; i < DEPTH; i++) slots[i] <= nxt[i];
                end
            end

            // Occupancy counter
            always_ff @(posedge clk) begin
                if (!rst_n)      cnt_q <= '0;
                else if (flush)  cnt_q <= push ? CW'(1) : '0;
                else if (push && !pop) cnt_q <= cnt_q + CW'(1);
                else if (pop && !push) cnt_q <= cnt_q - CW'(1);
            end

            // OR of the status of all occupied slots
            always_comb begin
                stat_or = '0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) < cnt_q) stat_or = stat_or | slots[i].status;
                end
            end

            assign head  = slots[0];
            assign empty = (cnt_q == '0);
            assign full  = (cnt_q == CW'(DEPTH));
            assign cnt   = cnt_q;
        end
    endgenerate

endmodule

// File: rtl/uel_log.sv
// Module: uel_log
// Visible log registers: first error pointer, header log, prefix log and
// the prefix-present bit. Load takes priority over clear. Assumes the
// loaded status is one-hot.
module uel_log
    import uel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  uel_entry_t       ent,
    input  logic             pfx_sup,
    output logic [PTR_W-1:0] fep,
    output logic             pfx_present,
    output logic [LOG_W-1:0] hdr_log,
    output logic [LOG_W-1:0] pfx_log
);

    logic keep_pfx;
    assign keep_pfx = ent.pfx_vld && pfx_sup;

    // Log register update from a load or a clear
    always_ff @(posedge clk) begin
        if (!rst_n || (clear && !load)) begin
            fep         <= '0;
            pfx_present <= 1'b0;
            hdr_log     <= '0;
            pfx_log     <= '0;
        end else if (load) begin
            fep         <= low_index(ent.status);
            hdr_log     <= ent.hdr_vld ? swap_dwords(ent.hdr) : '0;
            pfx_log     <= keep_pfx ? swap_dwords(ent.pfx) : '0;
            pfx_present <= keep_pfx;
        end
    end

endmodule

// File: rtl/uerr_first_log.sv
// Module: uerr_first_log
// Keeps the first uncorrectable error pointer and its header/prefix log,
// queues later errors while multiple header recording is on, pops them
// when software clears the pointed status bit, and reports the status
// bits to set again. Assumes the status register is held outside and
// stat_val shows its value after the write flagged by stat_wr.
module uerr_first_log
    import uel_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int MAX_DEPTH = 32,
    localparam int EFF_DEPTH = (DEPTH > MAX_DEPTH) ? MAX_DEPTH : DEPTH,
    localparam int CW        = (EFF_DEPTH > 0) ? $clog2(EFF_DEPTH + 1) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rec_en,
    input  logic         pfx_sup,
    input  logic         cap_wr,
    input  logic         log_req,
    input  logic [31:0]  log_status,
    input  logic         log_hdr_vld,
    input  logic         log_pfx_vld,
    input  logic [127:0] log_hdr,
    input  logic [127:0] log_pfx,
    input  logic         stat_wr,
    input  logic [31:0]  stat_val,
    output logic [4:0]   fep,
    output logic         pfx_present,
    output logic [127:0] hdr_log,
    output logic [127:0] pfx_log,
    output logic         overflow,
    output logic         reassert_vld,
    output logic [31:0]  reassert_mask,
    output logic         mhr_cap
);

    uel_entry_t      new_ent, head, load_ent;
    logic            q_empty, q_full;
    logic [STAT_W-1:0] q_or;
    logic [CW-1:0]   q_cnt;
    logic            rec_eff, ptr_set, clr_evt;
    logic            pop, push_want, push, load, clear;

    assign mhr_cap = (EFF_DEPTH > 0);
    assign rec_eff = rec_en && mhr_cap;

    // Pack the incoming request into an entry
    always_comb begin
        new_ent.status  = log_status;
        new_ent.hdr_vld = log_hdr_vld;
        new_ent.pfx_vld = log_pfx_vld;
        new_ent.hdr     = log_hdr;
        new_ent.pfx     = log_pfx;
    end

    // Decide pop, push, load and clear for this cycle
    always_comb begin
        ptr_set   = stat_val[fep];
        clr_evt   = stat_wr && !ptr_set;
        pop       = clr_evt && rec_eff && !q_empty && !cap_wr;
        push_want = log_req && rec_eff && (ptr_set || pop);
        push      = push_want && (!q_full || pop || cap_wr);
        load      = pop || (log_req && !push_want);
        clear     = clr_evt && !load;
        load_ent  = pop ? head : new_ent;
    end

    uel_queue #(.DEPTH(EFF_DEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (cap_wr),
        .push    (push),
        .pop     (pop),
        .din     (new_ent),
        .head    (head),
        .empty   (q_empty),
        .full    (q_full),
        .stat_or (q_or),
        .cnt     (q_cnt)
    );

    uel_log u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .clear       (clear),
        .ent         (load_ent),
        .pfx_sup     (pfx_sup),
        .fep         (fep),
        .pfx_present (pfx_present),
        .hdr_log     (hdr_log),
        .pfx_log     (pfx_log)
    );

    // Overflow pulse and status re-assert pulse with its mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow      <= 1'b0;
            reassert_vld  <= 1'b0;
            reassert_mask <= '0;
        end else begin
            overflow      <= push_want && !push;
            reassert_vld  <= stat_wr && rec_eff && !q_empty && !cap_wr;
            reassert_mask <= (stat_wr && rec_eff && !cap_wr) ? q_or : '0;
        end
    end

endmodule

// File: rtl/uel_chk.sv
// Module: uel_chk
// Property checker for uerr_first_log, attached by bind.
module uel_chk #(
    parameter int DEPTH = 4,
    localparam int CW   = (DEPTH > 0) ? $clog2(DEPTH + 1) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rec_en,
    input logic          cap_wr,
    input logic          log_req,
    input logic          stat_wr,
    input logic [31:0]   stat_val,
    input logic [4:0]    fep,
    input logic          pfx_present,
    input logic [127:0]  hdr_log,
    input logic [127:0]  pfx_log,
    input logic          overflow,
    input logic          reassert_vld,
    input logic [CW-1:0] q_cnt
);

    // R6
    ovf_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(log_req));

    // R9
    reassert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reassert_vld |-> $past(stat_wr && rec_en));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr |=> (q_cnt <= CW'(1)));

    // R5
    queued_keeps_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((DEPTH > 0) && log_req && rec_en && !stat_wr && stat_val[fep])
        |=> ($stable(fep) && $stable(hdr_log) && $stable(pfx_log)));

    // R7
    clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_val[fep] && q_cnt == '0 && !log_req)
        |=> (fep == '0 && !pfx_present && hdr_log == '0 && pfx_log == '0));

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CW'(DEPTH));

endmodule

bind uerr_first_log uel_chk #(.DEPTH(EFF_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_en       (rec_en),
    .cap_wr       (cap_wr),
    .log_req      (log_req),
    .stat_wr      (stat_wr),
    .stat_val     (stat_val),
    .fep          (fep),
    .pfx_present  (pfx_present),
    .hdr_log      (hdr_log),
    .pfx_log      (pfx_log),
    .overflow     (overflow),
    .reassert_vld (reassert_vld),
    .q_cnt        (q_cnt)
);

// File: tb/test_uerr_first_log.sv
module test_uerr_first_log;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rec_en = 1'b0, pfx_sup = 1'b0, cap_wr = 1'b0;
    logic         log_req = 1'b0, log_hdr_vld = 1'b0, log_pfx_vld = 1'b0;
    logic [31:0]  log_status = '0;
    logic [127:0] log_hdr = '0, log_pfx = '0;
    logic         stat_wr = 1'b0;
    logic [31:0]  stat_val = '0;
    logic [4:0]   fep;
    logic         pfx_present, overflow, reassert_vld, mhr_cap;
    logic [127:0] hdr_log, pfx_log;
    logic [31:0]  reassert_mask;

    int total = 0;
    int bad = 0;
    logic [31:0] st = '0;

    always #2.5 clk = ~clk;

    uerr_first_log i_uerr_first_log (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .pfx_sup(pfx_sup),
        .cap_wr(cap_wr), .log_req(log_req), .log_status(log_status),
        .log_hdr_vld(log_hdr_vld), .log_pfx_vld(log_pfx_vld),
        .log_hdr(log_hdr), .log_pfx(log_pfx), .stat_wr(stat_wr),
        .stat_val(stat_val), .fep(fep), .pfx_present(pfx_present),
        .hdr_log(hdr_log), .pfx_log(pfx_log), .overflow(overflow),
        .reassert_vld(reassert_vld), .reassert_mask(reassert_mask),
        .mhr_cap(mhr_cap)
    );

    // status, hdr_vld, pfx_vld, pfx_sup, expected pointer
    localparam logic [39:0] TBL [6] = '{
        {32'h0000_0010, 1'b1, 1'b1, 1'b1, 5'd4},
        {32'h8000_0000, 1'b1, 1'b1, 1'b0, 5'd31},
        {32'h0000_0001, 1'b0, 1'b1, 1'b1, 5'd0},
        {32'h0010_0000, 1'b1, 1'b0, 1'b1, 5'd20},
        {32'h0000_1000, 1'b0, 1'b0, 1'b0, 5'd12},
        {32'h0000_0004, 1'b1, 1'b1, 1'b1, 5'd2}
    };

    function automatic logic [127:0] mk_hdr(input logic [7:0] seed);
        logic [127:0] v;
        for (int k = 0; k < 4; k++) v[32*k +: 32] = {8'hA0 + 8'(k), seed, 8'h5C, 8'h10 + 8'(k)};
        return v;
    endfunction

    function automatic logic [127:0] mk_pfx(input logic [7:0] seed);
        return mk_hdr(seed) ^ 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    endfunction

    function automatic logic [127:0] be(input logic [127:0] v);
        logic [127:0] o;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] d;
            d = v[32*k +: 32];
            o[32*k +: 32] = {d[7:0], d[15:8], d[23:16], d[31:24]};
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        log_req = 1'b0; stat_wr = 1'b0; cap_wr = 1'b0;
    endtask

    task automatic send(input int bitn, input logic [7:0] seed, input logic hv, input logic pv);
        log_req     = 1'b1;
        log_status  = 32'd1 << bitn;
        log_hdr     = mk_hdr(seed);
        log_pfx     = mk_pfx(seed);
        log_hdr_vld = hv;
        log_pfx_vld = pv;
        stat_val    = st;
    endtask

    task automatic swr();
        stat_wr  = 1'b1;
        stat_val = st;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 fep", 128'(fep), 0);
        check("R1 hdr", hdr_log, 0);
        check("R1 pfx", pfx_log, 0);
        check("R1 flags", {125'd0, pfx_present, overflow, reassert_vld}, 0);

        // R2 R3 R4 table of direct log writes, recording off
        for (int n = 0; n < 6; n++) begin
            logic [39:0] e;
            e = TBL[n];
            pfx_sup = e[5];
            send(int'(i_bit(e[39:8])), 8'(n + 1), e[7], e[6]);
            tick();
            check("R2 fep", 128'(fep), 128'(e[4:0]));
            check("R3 hdr", hdr_log, e[7] ? be(mk_hdr(8'(n + 1))) : 128'd0);
            check("R4 pfx", pfx_log, (e[6] && e[5]) ? be(mk_pfx(8'(n + 1))) : 128'd0);
            check("R4 pfx_present", 128'(pfx_present), 128'(e[6] && e[5]));
            idle();
        end

        // Queue section
        rec_en = 1'b1; pfx_sup = 1'b1; st = '0;
        send(3, 8'd1, 1'b1, 1'b1); tick(); idle();
        check("R2 first load", 128'(fep), 3);
        st[3] = 1'b1;
        for (int n = 0; n < 4; n++) begin
            int b;
            b = (n == 0) ? 7 : (n == 1) ? 9 : (n == 2) ? 12 : 15;
            send(b, 8'(n + 2), 1'b1, 1'b1); tick(); idle();
            check("R5 queued fep", 128'(fep), 3);
            check("R5 queued hdr", hdr_log, be(mk_hdr(8'd1)));
            check("R6 no overflow", 128'(overflow), 0);
        end
        send(20, 8'd6, 1'b1, 1'b1); tick(); idle();
        check("R6 overflow", 128'(overflow), 1);
        check("R6 fep kept", 128'(fep), 3);
        tick();
        check("R6 pulse", 128'(overflow), 0);

        swr(); tick(); idle();
        check("R9 reassert vld", 128'(reassert_vld), 1);
        check("R9 reassert mask", 128'(reassert_mask), 128'(32'h0000_9280));
        check("R9 fep kept", 128'(fep), 3);

        st[3] = 1'b0;
        swr(); tick(); idle();
        check("R8 pop fep", 128'(fep), 7);
        check("R8 pop hdr", hdr_log, be(mk_hdr(8'd2)));
        check("R9 mask on pop", 128'(reassert_mask), 128'(32'h0000_9280));
        st = st | 32'h0000_9280;

        send(22, 8'd7, 1'b1, 1'b0); tick(); idle();
        check("R6 fill", 128'(overflow), 0);

        // R11 pop and push together on a full queue
        st[7] = 1'b0;
        swr(); send(25, 8'd8, 1'b1, 1'b0); tick(); idle();
        check("R11 pop fep", 128'(fep), 9);
        check("R11 no overflow", 128'(overflow), 0);
        check("R11 mask", 128'(reassert_mask), 128'(32'h0040_9200));
        st = st | 32'h0240_0000;
        send(26, 8'd9, 1'b1, 1'b0); tick(); idle();
        check("R11 still full", 128'(overflow), 1);

        // R8 remaining entries come back in arrival order
        for (int n = 0; n < 4; n++) begin
            int b, nb;
            logic [7:0] sd;
            b  = (n == 0) ? 9 : (n == 1) ? 12 : (n == 2) ? 15 : 22;
            nb = (n == 0) ? 12 : (n == 1) ? 15 : (n == 2) ? 22 : 25;
            sd = (n == 0) ? 8'd4 : (n == 1) ? 8'd5 : (n == 2) ? 8'd7 : 8'd8;
            st[b] = 1'b0;
            swr(); tick(); idle();
            check("R8 order fep", 128'(fep), 128'(nb));
            check("R8 order hdr", hdr_log, be(mk_hdr(sd)));
        end
        st[25] = 1'b0;
        swr(); tick(); idle();
        check("R7 empty clear fep", 128'(fep), 0);
        check("R7 empty clear hdr", hdr_log, 0);
        check("R7 empty clear pfx", {pfx_log, 1'b0} | 129'(pfx_present), 0);

        // R10 flush
        st = '0;
        send(4, 8'd10, 1'b1, 1'b1); tick(); idle();
        st[4] = 1'b1;
        send(5, 8'd11, 1'b1, 1'b1); tick(); idle();
        send(6, 8'd12, 1'b1, 1'b1); tick(); idle();
        cap_wr = 1'b1; tick(); idle();
        check("R10 log kept", 128'(fep), 4);
        swr(); tick(); idle();
        check("R10 no reassert", 128'(reassert_vld), 0);
        st[4] = 1'b0;
        swr(); tick(); idle();
        check("R10 clear no pop", 128'(fep), 0);
        check("R10 hdr clear", hdr_log, 0);

        // R5 with recording off, R7 with recording off
        rec_en = 1'b0; st = '0;
        send(8, 8'd13, 1'b1, 1'b0); tick(); idle();
        st[8] = 1'b1;
        send(10, 8'd14, 1'b1, 1'b0); tick(); idle();
        check("R5 rec off overwrite", 128'(fep), 10);
        check("R5 rec off hdr", hdr_log, be(mk_hdr(8'd14)));
        st = 32'h0000_0100;
        swr(); tick(); idle();
        check("R7 rec off clear", 128'(fep), 0);
        check("R7 rec off hdr", hdr_log, 0);

        // R7 clear and request in the same cycle loads the request
        swr(); send(17, 8'd15, 1'b1, 1'b0); tick(); idle();
        check("R7 load wins", 128'(fep), 17);

        // R12 capability
        check("R12 mhr_cap", 128'(mhr_cap), 1);

        finish_run();
    end

    function automatic logic [4:0] i_bit(input logic [31:0] v);
        logic [4:0] r;
        r = 0;
        for (int i = 0; i < 32; i++) if (v[i]) r = 5'(i);
        return r;
    endfunction

endmodule